// File: doc/BRIEF.md
# Countdown Timer Bank

This block holds a set of independent down-counting timer channels behind a small register port. Each channel keeps a reload value, a live count, a control word and a one-bit expiry flag. Once enabled, a channel counts down by one on every tick. When the count is zero, the next tick sets the flag and reloads the count, so the channel runs periodically until software turns it off. The channel's interrupt line is high while its flag is set and its interrupt is enabled.

A channel other than the first can take its tick from the expiry of the channel below it instead of from the clock. Two channels joined this way act as one wide counter. A single bit in a module-level register stops every channel at once. Software reaches the block through a single-cycle port: a write lands on the clock edge, and read data follows the address combinationally.

Top module: `cntdn_bank`

## Requirements
- R1: The register map is decoded as follows. The module register is at address 0x000. Channel n has its base at 0x100 + 0x10*n, with the reload value at +0x0, the live count at +0x4, the control word at +0x8 and the flag at +0xC. Control bit 0 is enable, bit 1 is interrupt enable and bit 2 is chain. The control word reads back in bits [2:0] and the flag in bit 0. All other bits read as zero.
- R2: While bit 1 of the module register is 1, no channel counts and no channel expires. The bit reads back at the same position.
- R3: A write that takes the enable bit from 0 to 1 loads the count from the reload value on that edge. Clearing enable and then setting it again therefore restarts the period.
- R4: An enabled channel with a nonzero count decrements by one per tick. With reload value L, one period lasts L+1 ticks.
- R5: On a tick with the count at zero, the channel expires and reloads the count from the reload value. It keeps running without stopping.
- R6: While enable is 0, the count holds its value and the channel never expires.
- R7: Writing the reload value while the channel runs leaves the current countdown untouched. The new value is used at the next reload.
- R8: An expiry sets the flag. Writing 1 to flag bit 0 clears it, and writing 0 leaves it unchanged. When an expiry and a clearing write fall on the same edge, the flag ends up set.
- R9: The interrupt output of a channel is high exactly while its flag is set and its interrupt-enable bit is 1.
- R10: A channel n>0 with the chain bit set ticks only on an edge where channel n-1 expires. The chain bit has no effect on channel 0, which always ticks once per clock.
- R11: After reset every register reads zero, and the module is enabled. Addresses that are unmapped or not word-aligned read as zero and ignore writes. Writes to the live-count register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Write strobe, applied on the clock edge |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt, level |

## Verification
The assertions assume that each clock carries at most one register access. They also assume that a restart can only come from a write that finds enable at 0. The count checks therefore accept a held value only where such a restart could occur. The stimulus uses a single write per cycle and never overlaps accesses. Chain and module-off intervals begin only after the previous settings have taken effect, so every cycle compared against the bench model stays within these assumptions.

// File: rtl/cntdn_pkg.sv
// Shared constants and types for the countdown timer bank.
// Assumes word-aligned byte addresses and a 12-bit-or-wider address.
package cntdn_pkg;
    localparam int unsigned CTL_EN      = 0;
    localparam int unsigned CTL_IE      = 1;
    localparam int unsigned CTL_CHAIN   = 2;
    localparam int unsigned CTL_W       = 3;
    localparam int unsigned MOD_OFF_BIT = 1;

    // Register slot inside one channel window, taken from address bits [3:2]
    typedef enum logic [1:0] {
        SLOT_LOAD  = 2'd0,
        SLOT_COUNT = 2'd1,
        SLOT_CTRL  = 2'd2,
        SLOT_FLAG  = 2'd3
    } slot_e;
endpackage

// File: rtl/cntdn_decode.sv
// Address decode and read multiplexer for the timer bank.
// Produces one-hot write strobes per channel register and the combinational
// read word. Assumes NCH <= 16 (channel index lives in address bits [7:4]).
module cntdn_decode
    import cntdn_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 12
) (
    input  logic [AW-1:0]              addr,
    input  logic                       wr,
    input  logic                       mod_off,
    input  logic [NCH-1:0][DW-1:0]     ld_v,
    input  logic [NCH-1:0][DW-1:0]     cnt_v,
    input  logic [NCH-1:0][CTL_W-1:0]  ctl_v,
    input  logic [NCH-1:0]             flg_v,
    output logic                       wr_mod,
    output logic [NCH-1:0]             wr_ld,
    output logic [NCH-1:0]             wr_ctl,
    output logic [NCH-1:0]             wr_flg,
    output logic [DW-1:0]              rdata
);
    localparam int          HIW  = AW - 8;
    localparam logic [4:0]  NCH5 = 5'(NCH);

    logic           hit_mod;
    logic           hit_win;
    logic [NCH-1:0] sel_ch;
    slot_e          slot;

    // Region decode: module word at zero, channel windows in page 1
    always_comb begin
        hit_mod = (addr == '0);
        hit_win = (addr[AW-1:8] == HIW'(1)) && ({1'b0, addr[7:4]} < NCH5)
                  && (addr[1:0] == 2'b00);
        slot    = slot_e'(addr[3:2]);
    end

    assign wr_mod = wr && hit_mod;

    for (genvar g = 0; g < NCH; g++) begin : g_stb
        assign sel_ch[g] = hit_win && (addr[7:4] == 4'(g));
        assign wr_ld[g]  = wr && sel_ch[g] && (slot == SLOT_LOAD);
        assign wr_ctl[g] = wr && sel_ch[g] && (slot == SLOT_CTRL);
        assign wr_flg[g] = wr && sel_ch[g] && (slot == SLOT_FLAG);
    end

    // Read word selection; unmapped addresses return zero
    always_comb begin
        rdata = '0;
        if (hit_mod) begin
            rdata[MOD_OFF_BIT] = mod_off;
        end
        for (int i = 0; i < NCH; i++) begin
            if (sel_ch[i]) begin
                case (slot)
                    SLOT_LOAD:  rdata = ld_v[i];
                    SLOT_COUNT: rdata = cnt_v[i];
                    SLOT_CTRL:  rdata = DW'(ctl_v[i]);
                    SLOT_FLAG:  rdata = DW'(flg_v[i]);
                    default:    rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cntdn_chan.sv
// One down-counting timer channel with reload, expiry flag and interrupt.
// Assumes tick is high for every cycle the channel may count (always high
// unless chained) and that at most one of the write strobes is set.
module cntdn_chan
    import cntdn_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_ld,
    input  logic              wr_ctl,
    input  logic              wr_flg,
    input  logic              mod_off,
    input  logic              tick,
    output logic [DW-1:0]     ld_q,
    output logic [DW-1:0]     cnt_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              flg_q,
    output logic              expire,
    output logic              irq
);
    logic run;
    logic start;

    // Count qualification, enable-rise detection and expiry
    always_comb begin
        run    = ctl_q[CTL_EN] && !mod_off && tick;
        start  = wr_ctl && wdata[CTL_EN] && !ctl_q[CTL_EN];
        expire = run && (cnt_q == '0);
        irq    = flg_q && ctl_q[CTL_IE];
    end

    // Live counter: load on enable rise, reload on expiry, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || expire) begin
            cnt_q <= ld_q;
        end else if (run) begin
            cnt_q <= cnt_q - DW'(1);
        end
    end

    // Reload value and control word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q  <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_ld)  ld_q  <= wdata;
            if (wr_ctl) ctl_q <= wdata[CTL_W-1:0];
        end
    end

    // Expiry flag: set has priority over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= 1'b0;
        end else if (expire) begin
            flg_q <= 1'b1;
        end else if (wr_flg && wdata[0]) begin
            flg_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cntdn_bank.sv
// Top of the countdown timer bank: module-off register, channel array with
// optional chaining of each channel to the expiry of the one below it, and
// the register port. Assumes one register access per clock.
module cntdn_bank
    import cntdn_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    parameter int AW  = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    logic                       mod_off_q;
    logic                       wr_mod;
    logic [NCH-1:0]             wr_ld, wr_ctl, wr_flg;
    logic [NCH-1:0][DW-1:0]     ld_v, cnt_v;
    logic [NCH-1:0][CTL_W-1:0]  ctl_v;
    logic [NCH-1:0]             flg_v, expire_v, tick_v;

    // Module-off bit; reset leaves the module running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_off_q <= 1'b0;
        end else if (wr_mod) begin
            mod_off_q <= bus_wdata[MOD_OFF_BIT];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        if (g == 0) begin : g_head
            assign tick_v[g] = 1'b1;
        end else begin : g_link
            assign tick_v[g] = ctl_v[g][CTL_CHAIN] ? expire_v[g-1] : 1'b1;
        end

        cntdn_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wdata   (bus_wdata),
            .wr_ld   (wr_ld[g]),
            .wr_ctl  (wr_ctl[g]),
            .wr_flg  (wr_flg[g]),
            .mod_off (mod_off_q),
            .tick    (tick_v[g]),
            .ld_q    (ld_v[g]),
            .cnt_q   (cnt_v[g]),
            .ctl_q   (ctl_v[g]),
            .flg_q   (flg_v[g]),
            .expire  (expire_v[g]),
            .irq     (irq[g])
        );
    end

    cntdn_decode #(.NCH(NCH), .DW(DW), .AW(AW)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .mod_off (mod_off_q),
        .ld_v    (ld_v),
        .cnt_v   (cnt_v),
        .ctl_v   (ctl_v),
        .flg_v   (flg_v),
        .wr_mod  (wr_mod),
        .wr_ld   (wr_ld),
        .wr_ctl  (wr_ctl),
        .wr_flg  (wr_flg),
        .rdata   (bus_rdata)
    );
endmodule

// File: rtl/cntdn_chk.sv
// Property checker for the countdown timer bank, bound to its top.
// Assumes one register access per clock.
module cntdn_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mod_off,
    input logic [NCH-1:0][DW-1:0] ld_v,
    input logic [NCH-1:0][DW-1:0] cnt_v,
    input logic [NCH-1:0][2:0]    ctl_v,
    input logic [NCH-1:0]         flg_v,
    input logic [NCH-1:0]         expire_v,
    input logic [NCH-1:0]         tick_v,
    input logic [NCH-1:0]         irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_prop
        a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_v[g][0] && !mod_off && tick_v[g] && cnt_v[g] != '0)
            |=> (cnt_v[g] == $past(cnt_v[g]) - DW'(1)));

        a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[g] |=> (cnt_v[g] == $past(ld_v[g])));

        a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            expire_v[g] |=> flg_v[g]);

        a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_v[g][0] |=> (cnt_v[g] == $past(cnt_v[g]) || ctl_v[g][0]));

        a_r2_module_off: assert property (@(posedge clk) disable iff (!rst_n)
            mod_off |=> (cnt_v[g] == $past(cnt_v[g])
                         || (ctl_v[g][0] && !$past(ctl_v[g][0]))));

        a_r9_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> flg_v[g]);

        if (g > 0) begin : g_chain
            a_r10_chain_wait: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_v[g][2] && !expire_v[g-1])
                |=> (cnt_v[g] == $past(cnt_v[g])
                     || (ctl_v[g][0] && !$past(ctl_v[g][0]))));
        end
    end
endmodule

bind cntdn_bank cntdn_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_off  (mod_off_q),
    .ld_v     (ld_v),
    .cnt_v    (cnt_v),
    .ctl_v    (ctl_v),
    .flg_v    (flg_v),
    .expire_v (expire_v),
    .tick_v   (tick_v),
    .irq      (irq)
);

// File: tb/sim_cntdn_bank.sv
module sim_cntdn_bank;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  a = '0;
    logic           w = 1'b0;
    logic [DW-1:0]  wd = '0;
    wire  [DW-1:0]  rd;
    wire  [NCH-1:0] irq;

    cntdn_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(a), .bus_wr(w),
        .bus_wdata(wd), .bus_rdata(rd), .irq(irq)
    );

    always #2 clk = ~clk;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    // Behavioural reference state
    logic [DW-1:0]  m_ld [NCH];
    logic [DW-1:0]  m_cv [NCH];
    logic [2:0]     m_ct [NCH];
    logic           m_fl [NCH];
    logic           m_off;
    logic [NCH-1:0] m_ex, m_run;
    logic           tk, hitc;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ch(int n, int off);
        return AW'(32'h100 + 16 * n + off);
    endfunction

    function automatic logic [DW-1:0] m_read(logic [AW-1:0] ad);
        logic [DW-1:0] r;
        int c;
        r = '0;
        if (ad == '0) r[1] = m_off;
        else if (ad[11:8] == 4'd1 && int'(ad[7:4]) < NCH && ad[1:0] == 2'b00) begin
            c = int'(ad[7:4]);
            case (ad[3:2])
                2'd0: r = m_ld[c];
                2'd1: r = m_cv[c];
                2'd2: r = DW'(m_ct[c]);
                default: r = DW'(m_fl[c]);
            endcase
        end
        return r;
    endfunction

    // Reference model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_ld[i] = '0; m_cv[i] = '0; m_ct[i] = '0; m_fl[i] = 1'b0;
            end
            m_off = 1'b0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (i == 0) tk = 1'b1;
                else        tk = m_ct[i][2] ? m_ex[i-1] : 1'b1;
                m_run[i] = m_ct[i][0] && !m_off && tk;
                m_ex[i]  = m_run[i] && (m_cv[i] == 0);
            end
            for (int i = 0; i < NCH; i++) begin
                hitc = w && a[11:8] == 4'd1 && int'(a[7:4]) == i && a[1:0] == 2'b00;
                if (hitc && a[3:2] == 2'd2 && wd[0] && !m_ct[i][0]) m_cv[i] = m_ld[i];
                else if (m_ex[i])  m_cv[i] = m_ld[i];
                else if (m_run[i]) m_cv[i] = m_cv[i] - 1;
                if (m_ex[i]) m_fl[i] = 1'b1;
                else if (hitc && a[3:2] == 2'd3 && wd[0]) m_fl[i] = 1'b0;
                if (hitc && a[3:2] == 2'd0) m_ld[i] = wd;
                if (hitc && a[3:2] == 2'd2) m_ct[i] = wd[2:0];
            end
            if (w && a == '0) m_off = wd[1];
        end
    end

    // Every-cycle comparison of readback (R4) and interrupts (R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 live readback", rd, m_read(a));
            for (int i = 0; i < NCH; i++)
                chk("R9 irq level", DW'(irq[i]), DW'(m_fl[i] && m_ct[i][1]));
        end
    end

    task automatic wr(logic [AW-1:0] ad, logic [DW-1:0] d);
        @(negedge clk); #1; a = ad; w = 1'b1; wd = d;
    endtask

    task automatic look(logic [AW-1:0] ad, int n);
        repeat (n) begin @(negedge clk); #1; w = 1'b0; a = ad; end
    endtask

    task automatic rdexp(logic [AW-1:0] ad, logic [DW-1:0] exp, string tag);
        @(negedge clk); #1; w = 1'b0; a = ad;
        @(negedge clk); chk(tag, rd, exp);
    endtask

    task automatic rdmod(logic [AW-1:0] ad, string tag);
        @(negedge clk); #1; w = 1'b0; a = ad;
        @(negedge clk); chk(tag, rd, m_read(ad));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R11 reset values, module enabled
        rdexp(12'h000, 0, "R11 reset module word");
        rdexp(ch(0, 0), 0, "R11 reset load");
        rdexp(ch(2, 8), 0, "R11 reset ctrl");
        chk("R11 reset irq", DW'(irq), 0);
        // R11 ignored writes
        wr(ch(1, 4), 32'h1234);
        wr(12'h010, 32'hFFFF_FFFF);
        wr(12'h140, 32'h55);
        wr(12'h102, 32'h77);
        rdexp(ch(1, 4), 0, "R11 count write ignored");
        rdexp(12'h010, 0, "R11 unmapped reads zero");
        rdexp(12'h140, 0, "R11 beyond last channel");
        rdexp(12'h000, 0, "R11 module word untouched");
        rdexp(ch(0, 0), 0, "R11 misaligned write ignored");
        // R1 R4 R5: channel 0, reload 5, interrupt on
        wr(ch(0, 0), 5);
        wr(ch(0, 8), 3);
        rdexp(ch(0, 8), 3, "R1 ctrl readback");
        look(ch(0, 4), 14);
        rdmod(ch(0, 12), "R5 flag after expiry");
        // R8 write zero keeps flag, write one clears (unless set wins)
        wr(ch(0, 12), 0);
        rdmod(ch(0, 12), "R8 write zero");
        wr(ch(0, 12), 1);
        rdmod(ch(0, 12), "R8 write one");
        // R7 reload write during run
        wr(ch(0, 0), 9);
        look(ch(0, 4), 25);
        // R3 restart
        wr(ch(0, 8), 0);
        look(ch(0, 4), 3);
        wr(ch(0, 8), 3);
        look(ch(0, 4), 4);
        // R2 module off
        wr(12'h000, 2);
        rdexp(12'h000, 2, "R2 module bit readback");
        look(ch(0, 4), 6);
        wr(12'h000, 0);
        look(ch(0, 4), 4);
        // R10 chaining channel 1 onto channel 0
        wr(ch(0, 0), 1);
        wr(ch(1, 0), 2);
        wr(ch(1, 8), 7);
        look(ch(1, 4), 30);
        rdmod(ch(1, 12), "R10 chained flag");
        // R10 chain bit on channel 0 has no effect
        wr(ch(0, 8), 7);
        look(ch(0, 4), 10);
        // R6 disabled channel holds
        wr(ch(1, 8), 0);
        look(ch(1, 4), 8);
        // R9 flag without interrupt enable
        wr(ch(2, 0), 3);
        wr(ch(2, 8), 1);
        look(ch(2, 12), 10);
        chk("R9 irq off without enable", DW'(irq[2]), 0);
        // R8 set wins: reload 0 expires every cycle
        wr(ch(3, 0), 0);
        wr(ch(3, 8), 3);
        look(ch(3, 4), 3);
        wr(ch(3, 12), 1);
        rdexp(ch(3, 12), 1, "R8 set wins over clear");
        wr(ch(3, 8), 2);
        wr(ch(3, 12), 1);
        rdexp(ch(3, 12), 0, "R8 clear after stop");
        look(ch(3, 4), 3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule